// File: doc/BRIEF.md
# Two-Stage Card Clock Divider with Data Timeout

This block derives a serial card clock from a faster reference clock. A 32-bit timing word carries three fields: a data-timeout count, an even prescale divisor and a rate divisor. The prescaler divides the reference clock first. The rate stage then divides the result again by one more than its field value. The card clock has an exact 50 % duty cycle. A one-reference-cycle enable pulse marks each rising edge of the card clock, so logic in the reference domain can act on card clock edges without sampling the clock itself.

A write to the timing word does not disturb the card clock period that is running. Both divisor fields are sampled only when the card clock rises, so every period is built entirely from one pair of values and no shortened pulse can appear.

The same word sets a data timeout, counted in units of 4096 card clock periods. A start strobe arms the timeout. An activity strobe restarts the window. When a full window passes with no activity, a sticky flag is raised. A timeout field of zero disables the flag.

Divider phase states: PH_LOW (card clock low) and PH_HIGH (card clock high). Both transitions are taken on the final half-period tick. The transition PH_LOW→PH_HIGH is also the reload point for the divisors. Timeout states: TO_IDLE, TO_RUN and TO_EXPIRED. The transitions are:
- TO_IDLE→TO_RUN on a start strobe with a nonzero field.
- TO_RUN→TO_EXPIRED when the window runs out.
- TO_RUN→TO_IDLE on a start strobe with a zero field.
- TO_EXPIRED→TO_RUN on a start strobe with a nonzero field.
- TO_EXPIRED→TO_IDLE on a start strobe with a zero field.

Top module: `card_clk_gen`

## Requirements
- R1: After reset the timing word holds a timeout of 0xFFFF, a prescale of 2 and a rate of 0, so the card clock period is 2 reference cycles.
- R2: The timing word layout is timeout in bits 31:16, prescale in bits 15:8 and rate in bits 7:0. The card clock period is prescale × (rate + 1) reference cycles.
- R3: An odd prescale is rounded down to the even value below it. A prescale of 0 or 1 acts as 2.
- R4: The card clock is high for exactly half of each period.
- R5: card_clk_en is high for exactly one reference cycle, and that cycle is the first cycle in which card_clk is high.
- R6: A write to the timing word lets the running card clock period finish with the old divisors. The new divisors apply from the next rising edge.
- R7: After a start strobe, to_flag rises one reference cycle after the enable pulse that completes timeout × 4096 counted card clock periods. The enable pulse present in the cycle of the start strobe is not counted.
- R8: An activity strobe while the timeout runs reloads the full window. The enable pulse present in the cycle of the activity strobe is not counted.
- R9: to_flag stays high until the next start strobe, and activity does not clear it. Any start strobe clears it in the following cycle.
- R10: A start strobe taken while the timeout field is 0 keeps to_flag low until a start strobe with a nonzero field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tw_wr | input | 1 | Timing word write strobe |
| tw_data | input | 32 | Timing word write data |
| to_start | input | 1 | Arm and reload the timeout |
| to_activity | input | 1 | Restart the timeout window while it runs |
| card_clk | output | 1 | Divided card clock |
| card_clk_en | output | 1 | One-cycle pulse marking each card clock rising edge |
| to_flag | output | 1 | Sticky timeout flag |

## Verification
A wrong divisor register or prescale count changes the spacing of the card_clk_en pulses. This is visible within one card clock period, so the bench measures whole periods and high phases under several field values. A divisor reload at the wrong point shows as an irregular period in the cycles just after a write. A wrong unit counter or wrong window reload appears as to_flag rising early or late. Because the window is thousands of periods long, the bench counts every enable pulse and checks the flag on the exact cycle before and after expiry.

// File: rtl/ccg_pkg.sv
package ccg_pkg;
    localparam int TMO_W    = 16;
    localparam int PRE_W    = 8;
    localparam int RATE_W   = 8;
    localparam int WORD_W   = TMO_W + PRE_W + RATE_W;
    localparam int HALF_W   = PRE_W - 1;

    // Field order in the packed struct fixes the bit positions of the word
    typedef struct packed {
        logic [TMO_W-1:0]  tmo;
        logic [PRE_W-1:0]  pre;
        logic [RATE_W-1:0] rate;
    } tword_t;

    localparam tword_t TWORD_RESET = '{tmo: {TMO_W{1'b1}}, pre: PRE_W'(2), rate: RATE_W'(0)};

    typedef enum logic {PH_LOW, PH_HIGH} phase_e;
    typedef enum logic [1:0] {TO_IDLE, TO_RUN, TO_EXPIRED} tostate_e;
endpackage

// File: rtl/ccg_timing_reg.sv
module ccg_timing_reg
    import ccg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [WORD_W-1:0] data,
    output tword_t            word_o,
    output logic [HALF_W-1:0] half_pre_o
);
    tword_t word_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= TWORD_RESET;
        end else if (wr) begin
            word_q <= tword_t'(data);
        end
    end

    // Half of the even prescale: dropping bit 0 rounds odd values down
    always_comb begin
        half_pre_o = word_q.pre[PRE_W-1:1];
        if (half_pre_o == '0) begin
            half_pre_o = HALF_W'(1);
        end
    end

    assign word_o = word_q;
endmodule

// File: rtl/ccg_divider.sv
module ccg_divider
    import ccg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [HALF_W-1:0] half_pre_i,
    input  logic [RATE_W-1:0] rate_i,
    output logic              card_clk,
    output logic              card_clk_en
);
    phase_e            phase, phase_nx;
    logic [HALF_W-1:0] pre_cnt, act_half;
    logic [RATE_W-1:0] rate_cnt, act_rate;
    logic              half_tick, toggle, rise, en_q;

    assign half_tick = (pre_cnt == act_half - HALF_W'(1));
    assign toggle    = half_tick && (rate_cnt == act_rate);
    assign rise      = toggle && (phase == PH_LOW);

    always_comb begin
        phase_nx = phase;
        unique case (phase)
            PH_LOW:  if (toggle) phase_nx = PH_HIGH;
            PH_HIGH: if (toggle) phase_nx = PH_LOW;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase <= PH_LOW;
        end else begin
            phase <= phase_nx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_cnt  <= '0;
            rate_cnt <= '0;
            act_half <= HALF_W'(1);
            act_rate <= '0;
            en_q     <= 1'b0;
        end else begin
            pre_cnt <= half_tick ? '0 : pre_cnt + HALF_W'(1);
            if (toggle) begin
                rate_cnt <= '0;
            end else if (half_tick) begin
                rate_cnt <= rate_cnt + RATE_W'(1);
            end
            // Divisors are reloaded only at a rising boundary
            if (rise) begin
                act_half <= half_pre_i;
                act_rate <= rate_i;
            end
            en_q <= rise;
        end
    end

    always_comb begin
        card_clk    = (phase == PH_HIGH);
        card_clk_en = en_q;
    end
endmodule

// File: rtl/ccg_timeout.sv
module ccg_timeout
    import ccg_pkg::*;
#(
    parameter int UNIT_CLKS = 4096
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             activity,
    input  logic             tick,
    input  logic [TMO_W-1:0] tmo_i,
    output logic             flag
);
    localparam int SUB_W = (UNIT_CLKS > 2) ? $clog2(UNIT_CLKS) : 1;
    localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(UNIT_CLKS - 1);

    tostate_e         state, state_nx;
    logic [TMO_W-1:0] units;
    logic [SUB_W-1:0] sub;
    logic             unit_wrap, reload;

    assign unit_wrap = tick && (sub == SUB_LAST);
    assign reload    = start || (activity && state == TO_RUN);

    always_comb begin
        state_nx = state;
        unique case (state)
            TO_IDLE: begin
                if (start && tmo_i != '0) state_nx = TO_RUN;
            end
            TO_RUN: begin
                if (start) begin
                    state_nx = (tmo_i != '0) ? TO_RUN : TO_IDLE;
                end else if (!activity && unit_wrap && units == TMO_W'(1)) begin
                    state_nx = TO_EXPIRED;
                end
            end
            TO_EXPIRED: begin
                if (start) state_nx = (tmo_i != '0) ? TO_RUN : TO_IDLE;
            end
            default: state_nx = TO_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= TO_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            units <= '0;
            sub   <= '0;
        end else if (reload) begin
            units <= tmo_i;
            sub   <= '0;
        end else if (state == TO_RUN && tick) begin
            if (unit_wrap) begin
                sub   <= '0;
                units <= units - TMO_W'(1);
            end else begin
                sub <= sub + SUB_W'(1);
            end
        end
    end

    always_comb begin
        flag = (state == TO_EXPIRED);
    end
endmodule

// File: rtl/card_clk_gen.sv
module card_clk_gen
    import ccg_pkg::*;
#(
    parameter int UNIT_CLKS = 4096
) (
    input  logic        clk_ref,
    input  logic        rst_n,
    input  logic        tw_wr,
    input  logic [31:0] tw_data,
    input  logic        to_start,
    input  logic        to_activity,
    output logic        card_clk,
    output logic        card_clk_en,
    output logic        to_flag
);
    tword_t            tword;
    logic [HALF_W-1:0] half_pre;
    logic [TMO_W-1:0]  tmo_val;

    ccg_timing_reg u_treg (
        .clk        (clk_ref),
        .rst_n      (rst_n),
        .wr         (tw_wr),
        .data       (tw_data[WORD_W-1:0]),
        .word_o     (tword),
        .half_pre_o (half_pre)
    );

    assign tmo_val = tword.tmo;

    ccg_divider u_div (
        .clk         (clk_ref),
        .rst_n       (rst_n),
        .half_pre_i  (half_pre),
        .rate_i      (tword.rate),
        .card_clk    (card_clk),
        .card_clk_en (card_clk_en)
    );

    ccg_timeout #(.UNIT_CLKS(UNIT_CLKS)) u_tmo (
        .clk      (clk_ref),
        .rst_n    (rst_n),
        .start    (to_start),
        .activity (to_activity),
        .tick     (card_clk_en),
        .tmo_i    (tmo_val),
        .flag     (to_flag)
    );
endmodule

// File: rtl/ccg_checker.sv
module ccg_checker
    import ccg_pkg::*;
(
    input logic             clk_ref,
    input logic             rst_n,
    input logic             card_clk,
    input logic             card_clk_en,
    input logic             to_start,
    input logic             to_flag,
    input logic [TMO_W-1:0] tmo_val
);
    logic        prev_clk, have_hi, zero_armed;
    logic [15:0] hi_run, lo_run, last_hi;

    always_ff @(posedge clk_ref or negedge rst_n) begin
        if (!rst_n) begin
            prev_clk   <= 1'b0;
            have_hi    <= 1'b0;
            hi_run     <= '0;
            lo_run     <= '0;
            last_hi    <= '0;
            zero_armed <= 1'b0;
        end else begin
            prev_clk <= card_clk;
            if (card_clk && !prev_clk) begin
                hi_run <= 16'd1;
            end else if (card_clk) begin
                hi_run <= hi_run + 16'd1;
            end
            if (!card_clk && prev_clk) begin
                lo_run  <= 16'd1;
                last_hi <= hi_run;
                have_hi <= 1'b1;
            end else if (!card_clk) begin
                lo_run <= lo_run + 16'd1;
            end
            if (to_start) begin
                zero_armed <= (tmo_val == '0);
            end
        end
    end

    a_r4_half_duty: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (card_clk && !prev_clk && have_hi) |-> (lo_run == last_hi));

    a_r5_en_at_rise: assert property (@(posedge clk_ref) disable iff (!rst_n)
        card_clk_en |-> (card_clk && !prev_clk));

    a_r5_en_single: assert property (@(posedge clk_ref) disable iff (!rst_n)
        card_clk_en |=> !card_clk_en);

    a_r9_flag_sticky: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (to_flag && !to_start) |=> to_flag);

    a_r9_start_clears: assert property (@(posedge clk_ref) disable iff (!rst_n)
        to_start |=> !to_flag);

    a_r10_zero_disabled: assert property (@(posedge clk_ref) disable iff (!rst_n)
        zero_armed |-> !to_flag);
endmodule

bind card_clk_gen ccg_checker u_ccg_checker (
    .clk_ref     (clk_ref),
    .rst_n       (rst_n),
    .card_clk    (card_clk),
    .card_clk_en (card_clk_en),
    .to_start    (to_start),
    .to_flag     (to_flag),
    .tmo_val     (tmo_val)
);

// File: tb/test_card_clk_gen.sv
`timescale 1ns/1ps
module test_card_clk_gen;
    logic        clk_ref = 1'b0;
    logic        rst_n = 1'b0;
    logic        tw_wr = 1'b0;
    logic [31:0] tw_data = '0;
    logic        to_start = 1'b0;
    logic        to_activity = 1'b0;
    logic        card_clk, card_clk_en, to_flag;
    int          checks = 0;
    int          errors = 0;

    always #2.5 clk_ref = ~clk_ref;

    card_clk_gen i_card_clk_gen (
        .clk_ref     (clk_ref),
        .rst_n       (rst_n),
        .tw_wr       (tw_wr),
        .tw_data     (tw_data),
        .to_start    (to_start),
        .to_activity (to_activity),
        .card_clk    (card_clk),
        .card_clk_en (card_clk_en),
        .to_flag     (to_flag)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic write_tw(input int tmo, input int pre, input int rate);
        @(negedge clk_ref);
        tw_wr   = 1'b1;
        tw_data = {tmo[15:0], pre[7:0], rate[7:0]};
        @(negedge clk_ref);
        tw_wr   = 1'b0;
    endtask

    task automatic wait_rise();
        do @(negedge clk_ref); while (!card_clk_en);
    endtask

    task automatic measure(output int per, output int high);
        wait_rise();
        per  = 0;
        high = 1;
        forever begin
            @(negedge clk_ref);
            per++;
            if (card_clk_en) break;
            if (card_clk) high++;
        end
    endtask

    task automatic t_reset();
        int per, high;
        check("R1 card_clk in reset", card_clk, 0);
        check("R1 card_clk_en in reset", card_clk_en, 0);
        check("R1 to_flag in reset", to_flag, 0);
        @(negedge clk_ref);
        rst_n = 1'b1;
        measure(per, high);
        check("R1 default period", per, 2);
        check("R4 default high phase", high, 1);
    endtask

    task automatic t_ratio(input string req, input int pre, input int rate, input int exp_per);
        int per, high;
        write_tw(16'hFFFF, pre, rate);
        measure(per, high);
        check({req, " period"}, per, exp_per);
        check("R4 high phase", high, exp_per / 2);
        measure(per, high);
        check({req, " period repeat"}, per, exp_per);
    endtask

    task automatic t_reprogram();
        int n, per, high;
        write_tw(16'hFFFF, 4, 1);
        measure(per, high);
        wait_rise();
        n = 0;
        repeat (2) begin @(negedge clk_ref); n++; end
        tw_wr   = 1'b1;
        tw_data = {16'hFFFF, 8'd6, 8'd0};
        @(negedge clk_ref);
        n++;
        tw_wr = 1'b0;
        do begin @(negedge clk_ref); n++; end while (!card_clk_en);
        check("R6 running period keeps old divisors", n, 8);
        measure(per, high);
        check("R6 next period uses new divisors", per, 6);
    endtask

    // Start the timeout; when act_at>=0, give activity after act_at pulses
    task automatic t_timeout(input string req, input int units, input int act_at);
        int cnt, target;
        bit acted;
        write_tw(units, 2, 0);
        target = units * 4096;
        acted  = 0;
        @(negedge clk_ref);
        to_start = 1'b1;
        cnt = 0;
        @(negedge clk_ref);
        to_start = 1'b0;
        if (card_clk_en) cnt++;
        check({req, " flag cleared by start"}, to_flag, 0);
        while (cnt < target) begin
            @(negedge clk_ref);
            to_activity = 1'b0;
            if (card_clk_en) cnt++;
            if (!acted && act_at >= 0 && cnt == act_at) begin
                acted = 1;
                check("R8 no flag before activity", to_flag, 0);
                to_activity = 1'b1;
                cnt = 0;
            end
        end
        check({req, " flag low on final pulse"}, to_flag, 0);
        @(negedge clk_ref);
        to_activity = 1'b0;
        check({req, " flag high after final pulse"}, to_flag, 1);
    endtask

    task automatic t_sticky();
        repeat (100) @(negedge clk_ref);
        check("R9 flag stays high", to_flag, 1);
        to_activity = 1'b1;
        @(negedge clk_ref);
        to_activity = 1'b0;
        repeat (3) @(negedge clk_ref);
        check("R9 activity does not clear flag", to_flag, 1);
    endtask

    task automatic t_zero();
        write_tw(0, 2, 0);
        to_start = 1'b1;
        @(negedge clk_ref);
        to_start = 1'b0;
        @(negedge clk_ref);
        check("R9 start clears flag", to_flag, 0);
        repeat (9000) @(negedge clk_ref);
        check("R10 zero timeout never flags", to_flag, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk_ref);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk_ref);
        t_reset();
        t_ratio("R2 pre4 rate0", 4, 0, 4);
        t_ratio("R2 pre6 rate2", 6, 2, 18);
        t_ratio("R3 odd pre7 rate1", 7, 1, 12);
        t_ratio("R3 pre0 rate3", 0, 3, 8);
        t_ratio("R3 pre1 rate0", 1, 0, 2);
        t_reprogram();
        t_timeout("R7 one unit", 1, -1);
        t_sticky();
        t_timeout("R7 two units", 2, -1);
        t_timeout("R8 activity reload", 1, 3000);
        t_zero();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule